// File: doc/BRIEF.md
# Indirect PLL Configuration Register Port

This block is a byte-wide slave that lets a host reach a bank of internal clock-synthesizer configuration registers through two byte locations. The first location is a pointer byte: the host stores a register index in its upper six bits and an arm flag in bit 1. The second location is a window byte: reading it returns the register that the stored index selects, and writing it updates that register, but only while the stored arm flag is set.

The bank holds 64 eight-bit registers, all cleared by reset. Software normally arms the pointer, writes the window, and then rewrites the pointer with the flag cleared, so that a stray window write cannot change anything. Three register fields drive the clock logic directly on dedicated outputs: a 2-bit pixel-clock post-divider code, an 8-bit pixel-clock feedback divider and an 8-bit reference divider.

Top module: `pll_indirect_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer byte reads 0x00, every register reads 0x00 and all three field outputs are zero.
- R2: A bus write with `bus_sel`=0 stores bits [7:2] as the register index and bit 1 as the arm flag. Reading with `bus_sel`=0 returns {index, arm, 1'b0}, so bit 0 always reads zero.
- R3: A bus write with `bus_sel`=1 while the arm flag is set stores the byte in the indexed register. The new value is visible from the cycle after the write edge.
- R4: A bus write with `bus_sel`=1 while the arm flag is clear changes no register.
- R5: With `bus_sel`=1, `bus_rdata` returns the current contents of the register selected by the stored index, whatever the arm flag is.
- R6: After the arm, write, disarm sequence, further window writes leave the written value in place.
- R7: `pix_post_code` equals bits [1:0] of register 5. A read-modify-write of that register keeps its bits [7:2].
- R8: `pix_fb_div` equals register 7, and `ref_div` equals register 2.
- R9: A write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe, one cycle per write |
| bus_sel | input | 1 | Byte location: 0 is the pointer, 1 is the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the location selected by `bus_sel` |
| pix_post_code | output | 2 | Pixel-clock post-divider code |
| pix_fb_div | output | 8 | Pixel-clock feedback divider |
| ref_div | output | 8 | Reference divider |

## Verification
Every write is committed at the clock edge on which the strobe is sampled. Read data is combinational from the stored state, so the result of a write is due on `bus_rdata` and on the field outputs in the cycle that follows that edge. The bench drives strobes on falling edges and drops them one falling edge later. It then samples outputs a quarter period after that falling edge, which keeps every sample clear of the rising edge. The bench sweeps all 64 indices with the arm flag both set and clear, and compares every readback against a shadow copy kept in the bench.

// File: rtl/pll_port_pkg.sv
// Package: shared widths and the layout of the pointer byte.
// Assumes the index field plus the two flag bits fill exactly one byte.
package pll_port_pkg;
    parameter int unsigned BYTE_W  = 8;
    parameter int unsigned IDX_W   = 6;
    localparam int unsigned IDX_LSB = BYTE_W - IDX_W;
    localparam int unsigned ARM_BIT = 1;
    localparam int unsigned NUM_REGS = 1 << IDX_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/pll_ptr_latch.sv
// Module: holds the pointer byte (register index plus arm flag).
// Assumes a single-cycle load strobe. Bit 0 of the byte is not stored.
module pll_ptr_latch
    import pll_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t wdata,
    output idx_t  idx,
    output logic  armed,
    output byte_t ptr_rb
);
    // Capture the index and arm flag on a pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            idx   <= wdata[BYTE_W-1:IDX_LSB];
            armed <= wdata[ARM_BIT];
        end
    end

    // Rebuild the readback byte. The unstored bit 0 reads as zero.
    always_comb begin
        ptr_rb = {idx, armed, 1'b0};
    end

    a_r2_ptr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == $past(wdata[BYTE_W-1:IDX_LSB])) && (armed == $past(wdata[ARM_BIT])));
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(idx) && $stable(armed));
endmodule

// File: rtl/pll_reg_bank.sv
// Module: the configuration register file and its fixed field taps.
// Assumes the index does not change in a cycle that carries a window write.
module pll_reg_bank
    import pll_port_pkg::*;
#(
    parameter int unsigned POST_IDX = 5,
    parameter int unsigned POST_W   = 2,
    parameter int unsigned FB_IDX   = 7,
    parameter int unsigned REF_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              armed,
    input  idx_t              idx,
    input  byte_t             wdata,
    output byte_t             cur_word,
    output logic [POST_W-1:0] post_code,
    output byte_t             fb_word,
    output byte_t             ref_word
);
    byte_t mem [NUM_REGS];
    logic  commit;

    // A window write lands only while the pointer is armed.
    always_comb begin
        commit = wr_req && armed;
    end

    // Each register clears on reset and loads when its index commits.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (commit && (idx == idx_t'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    // Select the indexed register and drive the fixed taps.
    always_comb begin
        cur_word  = mem[idx];
        post_code = mem[POST_IDX][POST_W-1:0];
        fb_word   = mem[FB_IDX];
        ref_word  = mem[REF_IDX];
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && armed) |=> cur_word == $past(wdata));
    a_r4_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !armed) |=> $stable(cur_word));
endmodule

// File: rtl/pll_read_mux.sv
// Module: chooses which byte location is returned to the host.
// Assumes a combinational read with no side effects.
module pll_read_mux
    import pll_port_pkg::*;
(
    input  logic  sel,
    input  byte_t ptr_rb,
    input  byte_t cur_word,
    output byte_t rdata
);
    // Location 0 is the pointer byte, location 1 is the window.
    always_comb begin
        rdata = sel ? cur_word : ptr_rb;
    end
endmodule

// File: rtl/pll_indirect_port.sv
// Module: top of the indirect clock-configuration register port.
// Assumes at most one byte strobe per cycle, with bus_sel picking the location.
module pll_indirect_port
    import pll_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [1:0] pix_post_code,
    output logic [7:0] pix_fb_div,
    output logic [7:0] ref_div
);
    localparam int unsigned POST_IDX = 5;
    localparam int unsigned FB_IDX   = 7;
    localparam int unsigned REF_IDX  = 2;

    logic  ptr_load, win_wr, armed;
    idx_t  idx;
    byte_t ptr_rb, cur_word;

    // Split the byte strobe between the two locations.
    always_comb begin
        ptr_load = bus_wr && !bus_sel;
        win_wr   = bus_wr && bus_sel;
    end

    pll_ptr_latch u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ptr_load),
        .wdata  (bus_wdata),
        .idx    (idx),
        .armed  (armed),
        .ptr_rb (ptr_rb)
    );

    pll_reg_bank #(
        .POST_IDX (POST_IDX),
        .POST_W   (2),
        .FB_IDX   (FB_IDX),
        .REF_IDX  (REF_IDX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (win_wr),
        .armed     (armed),
        .idx       (idx),
        .wdata     (bus_wdata),
        .cur_word  (cur_word),
        .post_code (pix_post_code),
        .fb_word   (pix_fb_div),
        .ref_word  (ref_div)
    );

    pll_read_mux u_rmux (
        .sel      (bus_sel),
        .ptr_rb   (ptr_rb),
        .cur_word (cur_word),
        .rdata    (bus_rdata)
    );

    a_r7_post_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && armed && idx == idx_t'(POST_IDX)) |=> pix_post_code == $past(bus_wdata[1:0]));
    a_r8_fb_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && armed && idx == idx_t'(FB_IDX)) |=> pix_fb_div == $past(bus_wdata));
endmodule

// File: tb/pll_indirect_port_tb.sv
// Bench: sweeps every register index with the arm flag set and clear,
// and compares all readback against a shadow model kept in the bench.
module pll_indirect_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] pix_post_code;
    logic [7:0] pix_fb_div;
    logic [7:0] ref_div;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [64];

    always #10 clk = ~clk;   // 50 MHz

    pll_indirect_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_post_code(pix_post_code), .pix_fb_div(pix_fb_div), .ref_div(ref_div)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One strobe: drive on a falling edge, release on the next one.
    task automatic put(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational readback, sampled a quarter period after a falling edge.
    task automatic get(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel;
        #5 d = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        get(1'b0, rd); check("R1 ptr", rd, 8'h00);
        get(1'b1, rd); check("R1 reg0", rd, 8'h00);
        check("R1 post", {6'b0, pix_post_code}, 8'h00);
        check("R1 fb", pix_fb_div, 8'h00);
        check("R1 ref", ref_div, 8'h00);

        // R2/R3: armed pointer then window write, for every index
        for (int i = 0; i < 64; i++) begin
            put(1'b0, {6'(i), 2'b10});
            get(1'b0, rd); check("R2 ptr armed", rd, {6'(i), 2'b10});
            put(1'b1, pat(i)); shadow[i] = pat(i);
            get(1'b1, rd); check("R3 armed write", rd, pat(i));
        end

        // R4/R5: disarmed pointer; reads work and window writes are dropped
        for (int i = 0; i < 64; i++) begin
            put(1'b0, {6'(i), 2'b00});
            get(1'b1, rd); check("R5 read", rd, shadow[i]);
            put(1'b1, ~pat(i));
            get(1'b1, rd); check("R4 locked write", rd, shadow[i]);
        end

        // R2/R9: bit 0 written high reads back zero; no register disturbed
        for (int i = 0; i < 64; i++) begin
            put(1'b0, {6'(i), 2'b01});
            get(1'b0, rd); check("R2 bit0 zero", rd, {6'(i), 2'b00});
            get(1'b1, rd); check("R9 isolation", rd, shadow[i]);
        end

        // R8: taps follow registers 7 and 2
        check("R8 fb tap", pix_fb_div, shadow[7]);
        check("R8 ref tap", ref_div, shadow[2]);

        // R6: arm, write, disarm, then a stray write
        put(1'b0, {6'd7, 2'b10});
        put(1'b1, 8'hC8); shadow[7] = 8'hC8;
        put(1'b0, {6'd7, 2'b00});
        put(1'b1, 8'h11);
        get(1'b1, rd); check("R6 after disarm", rd, 8'hC8);
        check("R8 fb after seq", pix_fb_div, 8'hC8);

        // R7: read-modify-write of the post-divider code, all four codes
        for (int c = 0; c < 4; c++) begin
            put(1'b0, {6'd5, 2'b10});
            get(1'b1, rd);
            put(1'b1, (rd & 8'hFC) | 8'(c));
            shadow[5] = (shadow[5] & 8'hFC) | 8'(c);
            check("R7 post code", {6'b0, pix_post_code}, 8'(c));
            get(1'b1, rd); check("R7 upper kept", rd, shadow[5]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule